// File: doc/BRIEF.md
# USART Baud Rate Prescaler with Shared-Address Divisor Register

This block produces the bit-rate tick for a serial port and the edge strobes used by its synchronous mode. A byte-wide register bus loads a 12-bit divisor through two locations. The low location holds the eight least significant divisor bits. The high location holds the upper nibble. That high location is shared with a frame-control register. Bit 7 of every byte written there decides which of the two registers takes the write.

A down counter runs from the divisor value to zero. It raises `baudTick` for one cycle at zero and then reloads, so the tick period is the divisor plus one clock. A write to the low location reloads the counter at once with the full 12-bit value. A write to the high nibble alone only changes the stored divisor, which the counter picks up at its next reload.

An external serial clock, `xckIn`, is synchronized into the system clock domain and edge-detected. The detected edges become single-cycle strobes that mark when transmit data should change (`txChange`) and when receive data should be sampled (`rxSample`). A polarity bit in the frame-control register decides which edge drives which strobe. That bit only counts when the sync-mode bit is also set.

Top module: `uart_rate_engine`

## Requirements
- R1: After reset the divisor, the frame-control register and the counter are zero. `baudTick` is then high on every cycle, and both bus locations read back 0x00.
- R2: A write to address 0 stores the divisor low byte. A write to address 1 with bit 7 = 0 stores bits 3:0 as divisor bits 11:8. Both values read back unchanged.
- R3: A read of address 1 returns the divisor high nibble in bits 3:0, with bits 7:4 always zero, whatever byte was written.
- R4: A write to address 1 with bit 7 = 1 stores bits 6:0 into the frame-control register, shown on `frameCtrl`, and leaves the divisor unchanged.
- R5: A write to address 0 reloads the counter on that clock edge with {high nibble, written byte}. The first `baudTick` follows exactly D cycles later, where D is the 12-bit divisor.
- R6: In steady state `baudTick` is a single-cycle pulse with a period of D+1 cycles. With D = 0 it stays high.
- R7: A high-nibble write does not restart the counter. The tick already scheduled arrives on time, and only the period after it uses the new divisor.
- R8: With sync mode set (`frameCtrl[6]` = 1) and polarity clear (`frameCtrl[0]` = 0), a rising `xckIn` edge gives `txChange` and a falling edge gives `rxSample`.
- R9: With sync mode and polarity both set, a falling edge gives `txChange` and a rising edge gives `rxSample`.
- R10: With sync mode clear, the polarity bit is treated as 0 and the edges map as in R8.
- R11: A strobe is one cycle wide and appears three clock edges after the `xckIn` change, on the edge that follows the two synchronizer stages. `txChange` and `rxSample` are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWe | input | 1 | Register write enable for one cycle |
| busAddr | input | 1 | 0 = divisor low byte, 1 = shared high/frame location |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data for the addressed location |
| frameCtrl | output | 7 | Frame-control register contents |
| baudTick | output | 1 | One-cycle tick when the counter is zero |
| xckIn | input | 1 | External synchronous serial clock |
| txChange | output | 1 | Strobe: transmit data should change |
| rxSample | output | 1 | Strobe: receive data should be sampled |

## Verification
A wrong counter value shows up as a tick that comes early or late. It is seen at the first tick after a low-byte write, so the first interval and the following period are both measured. A bad decode at the shared address shows up on the next read-back or on `frameCtrl` in the cycle after the write. A bad polarity or mode path swaps the two strobes. That swap is visible three cycles after an `xckIn` edge, so every edge is checked for which strobe fires, when it fires, and for how long.

// File: rtl/rate_pkg.sv
package rate_pkg;
  typedef struct packed {
    logic loadLow;
    logic writeHigh;
    logic writeFrame;
  } regStrobes_t;
endpackage

// File: rtl/rate_ctrl.sv
module rate_ctrl
  import rate_pkg::*;
#(
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic              busAddr,
  input  logic [BYTE_W-1:0] busWdata,
  input  logic              xckIn,
  input  logic              syncMode,
  input  logic              polarity,
  output regStrobes_t       strobes,
  output logic              txChange,
  output logic              rxSample
);
  localparam int SEL_BIT = BYTE_W - 1;

  // register decode: the select bit steers writes at the shared location
  always_comb begin
    strobes.loadLow    = busWe && !busAddr;
    strobes.writeHigh  = busWe && busAddr && !busWdata[SEL_BIT];
    strobes.writeFrame = busWe && busAddr && busWdata[SEL_BIT];
  end

  logic [SYNC_STAGES-1:0] syncChain;
  logic                   prevLevel;

  generate
    if (SYNC_STAGES == 1) begin : gSingle
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) syncChain <= '0;
        else       syncChain <= xckIn;
    end else begin : gMulti
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) syncChain <= '0;
        else       syncChain <= {syncChain[SYNC_STAGES-2:0], xckIn};
    end
  endgenerate

  logic syncLevel;
  logic edgeRise;
  logic edgeFall;
  logic effPol;

  assign syncLevel = syncChain[SYNC_STAGES-1];
  assign edgeRise  = syncLevel && !prevLevel;
  assign edgeFall  = !syncLevel && prevLevel;
  assign effPol    = polarity && syncMode;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevLevel <= 1'b0;
      txChange  <= 1'b0;
      rxSample  <= 1'b0;
    end else begin
      prevLevel <= syncLevel;
      txChange  <= effPol ? edgeFall : edgeRise;
      rxSample  <= effPol ? edgeRise : edgeFall;
    end
  end
endmodule

// File: rtl/rate_dp.sv
module rate_dp
  import rate_pkg::*;
#(
  parameter int DIV_W    = 12,
  parameter int BYTE_W   = 8,
  parameter int SYNC_BIT = 6,
  parameter int POL_BIT  = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStrobes_t       strobes,
  input  logic              busAddr,
  input  logic [BYTE_W-1:0] busWdata,
  output logic [BYTE_W-1:0] busRdata,
  output logic [BYTE_W-2:0] frameCtrl,
  output logic              syncMode,
  output logic              polarity,
  output logic              baudTick,
  output logic [DIV_W-1:0]  countVal,
  output logic [DIV_W-1:0]  divisor
);
  localparam int HI_W  = DIV_W - BYTE_W;
  localparam int PAD_W = BYTE_W - HI_W;

  logic [BYTE_W-1:0] divLo;
  logic [HI_W-1:0]   divHi;
  logic [BYTE_W-2:0] frameReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divLo    <= '0;
      divHi    <= '0;
      frameReg <= '0;
    end else begin
      if (strobes.loadLow)    divLo    <= busWdata;
      if (strobes.writeHigh)  divHi    <= busWdata[HI_W-1:0];
      if (strobes.writeFrame) frameReg <= busWdata[BYTE_W-2:0];
    end
  end

  assign divisor = {divHi, divLo};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  countVal <= '0;
    else if (strobes.loadLow)   countVal <= {divHi, busWdata};
    else if (countVal == '0)    countVal <= divisor;
    else                        countVal <= countVal - 1'b1;
  end

  assign baudTick  = (countVal == '0);
  assign busRdata  = busAddr ? {{PAD_W{1'b0}}, divHi} : divLo;
  assign frameCtrl = frameReg;
  assign syncMode  = frameReg[SYNC_BIT];
  assign polarity  = frameReg[POL_BIT];
endmodule

// File: rtl/uart_rate_engine.sv
module uart_rate_engine
  import rate_pkg::*;
#(
  parameter int DIV_W       = 12,
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic              busAddr,
  input  logic [BYTE_W-1:0] busWdata,
  output logic [BYTE_W-1:0] busRdata,
  output logic [BYTE_W-2:0] frameCtrl,
  output logic              baudTick,
  input  logic              xckIn,
  output logic              txChange,
  output logic              rxSample
);
  regStrobes_t      strobes;
  logic             syncMode;
  logic             polarity;
  logic [DIV_W-1:0] countVal;
  logic [DIV_W-1:0] divisor;

  rate_ctrl #(.BYTE_W(BYTE_W), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .xckIn(xckIn), .syncMode(syncMode),
    .polarity(polarity), .strobes(strobes), .txChange(txChange),
    .rxSample(rxSample)
  );

  rate_dp #(.DIV_W(DIV_W), .BYTE_W(BYTE_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .frameCtrl(frameCtrl),
    .syncMode(syncMode), .polarity(polarity), .baudTick(baudTick),
    .countVal(countVal), .divisor(divisor)
  );
endmodule

// File: rtl/rate_engine_checker.sv
module rate_engine_checker #(
  parameter int DIV_W  = 12,
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              busWe,
  input logic              busAddr,
  input logic [BYTE_W-1:0] busWdata,
  input logic [BYTE_W-1:0] busRdata,
  input logic              baudTick,
  input logic              txChange,
  input logic              rxSample,
  input logic [DIV_W-1:0]  countVal,
  input logic [DIV_W-1:0]  divisor
);
  localparam int HI_W = DIV_W - BYTE_W;

  assert_low_reload_R5: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && !busAddr) |=> countVal == {divisor[DIV_W-1:BYTE_W], $past(busWdata)});

  assert_tick_reload_R6: assert property (@(posedge clk) disable iff (!rstN)
    (baudTick && !(busWe && !busAddr)) |=> countVal == $past(divisor));

  assert_no_restart_R7: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr && countVal != '0) |=> countVal == DIV_W'($past(countVal) - 1'b1));

  assert_reserved_zero_R3: assert property (@(posedge clk) disable iff (!rstN)
    busAddr |-> busRdata[BYTE_W-1:HI_W] == '0);

  assert_tx_one_wide_R11: assert property (@(posedge clk) disable iff (!rstN)
    txChange |=> !txChange);

  assert_rx_one_wide_R11: assert property (@(posedge clk) disable iff (!rstN)
    rxSample |=> !rxSample);

  assert_exclusive_R11: assert property (@(posedge clk) disable iff (!rstN)
    !(txChange && rxSample));
endmodule

bind uart_rate_engine rate_engine_checker #(.DIV_W(DIV_W), .BYTE_W(BYTE_W)) u_chk (
  .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr),
  .busWdata(busWdata), .busRdata(busRdata), .baudTick(baudTick),
  .txChange(txChange), .rxSample(rxSample), .countVal(countVal),
  .divisor(divisor)
);

// File: tb/sim_uart_rate_engine.sv
`timescale 1ns/1ps
module sim_uart_rate_engine;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       busWe = 1'b0;
  logic       busAddr = 1'b0;
  logic [7:0] busWdata = '0;
  logic [7:0] busRdata;
  logic [6:0] frameCtrl;
  logic       baudTick;
  logic       xckIn = 1'b0;
  logic       txChange;
  logic       rxSample;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_rate_engine u0 (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .frameCtrl(frameCtrl),
    .baudTick(baudTick), .xckIn(xckIn), .txChange(txChange),
    .rxSample(rxSample)
  );

  function automatic int divOf(input int hi, input int lo);
    return ((hi & 15) << 8) | (lo & 255);
  endfunction

  function automatic int hiReadback(input int hi);
    return hi & 15;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic busWrite(input bit addr, input logic [7:0] data);
    busWe = 1'b1; busAddr = addr; busWdata = data;
    @(posedge clk); @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic busRead(input bit addr, output int val);
    busAddr = addr; #1; val = busRdata;
  endtask

  // counts negedges until baudTick, starting at index 'start'
  task automatic waitTick(input int start, input int limit, output int idx);
    idx = -1;
    for (int k = start; k <= limit; k++) begin
      if (baudTick) begin idx = k; break; end
      @(negedge clk);
    end
  endtask

  // writes divisor, returns first tick index and following period
  task automatic loadAndMeasure(input int hi, input int lo, output int first, output int period);
    int t2;
    busWrite(1'b1, 8'(hi & 15));
    busWrite(1'b0, 8'(lo));
    waitTick(0, 5000, first);
    @(negedge clk);
    waitTick(1, 5000, t2);
    period = t2;
  endtask

  // xck edge, returns tx/rx counts and index of first strobe
  task automatic xckEdge(input bit lvl, output int txN, output int rxN, output int at);
    txN = 0; rxN = 0; at = -1;
    xckIn = lvl;
    for (int i = 1; i <= 6; i++) begin
      @(negedge clk);
      if (txChange) txN++;
      if (rxSample) rxN++;
      if ((txChange || rxSample) && at < 0) at = i;
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int v, f, p, txN, rxN, at, idx, seed;
    seed = $urandom(32'h5eed1234);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    busRead(1'b0, v); check(v == 0, "R1 low readback", v, 0);
    busRead(1'b1, v); check(v == 0, "R1 high readback", v, 0);
    check(frameCtrl == 0, "R1 frameCtrl", frameCtrl, 0);
    v = 0;
    for (int i = 0; i < 5; i++) begin if (baudTick) v++; @(negedge clk); end
    check(v == 5, "R1 tick every cycle", v, 5);

    // R2/R3 readback with reserved bits written as ones
    busWrite(1'b1, 8'h7A);
    busRead(1'b1, v); check(v == hiReadback(8'h7A), "R3 high readback masked", v, hiReadback(8'h7A));
    busWrite(1'b0, 8'hC5);
    busRead(1'b0, v); check(v == 8'hC5, "R2 low readback", v, 8'hC5);

    // R4 frame write leaves divisor alone
    busWrite(1'b1, 8'hC1);
    check(frameCtrl == 7'h41, "R4 frameCtrl", frameCtrl, 7'h41);
    busRead(1'b1, v); check(v == 10, "R4 divisor high kept", v, 10);
    busRead(1'b0, v); check(v == 8'hC5, "R4 divisor low kept", v, 8'hC5);
    busWrite(1'b1, 8'h80);

    // R5/R6 directed: zero, small, with high nibble
    loadAndMeasure(0, 0, f, p);
    check(f == 0, "R5 first tick D=0", f, 0);
    check(p == 1, "R6 period D=0", p, 1);
    loadAndMeasure(0, 7, f, p);
    check(f == 7, "R5 first tick D=7", f, 7);
    check(p == 8, "R6 period D=7", p, 8);
    loadAndMeasure(1, 5, f, p);
    check(f == divOf(1, 5), "R5 first tick D=261", f, divOf(1, 5));
    check(p == divOf(1, 5) + 1, "R6 period D=261", p, divOf(1, 5) + 1);

    // R7 high write mid-count does not restart
    busWrite(1'b1, 8'h00);
    busWrite(1'b0, 8'd10);
    repeat (3) @(negedge clk);
    busWrite(1'b1, 8'h01);
    waitTick(4, 5000, idx);
    check(idx == 10, "R7 scheduled tick on time", idx, 10);
    @(negedge clk);
    waitTick(1, 5000, idx);
    check(idx == divOf(1, 10) + 1, "R7 next period uses new divisor", idx, divOf(1, 10) + 1);

    // R8 sync, polarity 0
    busWrite(1'b1, 8'hC0);
    xckEdge(1'b1, txN, rxN, at);
    check(txN == 1 && rxN == 0, "R8 rise gives tx", txN * 10 + rxN, 10);
    check(at == 3, "R11 strobe latency", at, 3);
    xckEdge(1'b0, txN, rxN, at);
    check(txN == 0 && rxN == 1, "R8 fall gives rx", txN * 10 + rxN, 1);

    // R9 sync, polarity 1
    busWrite(1'b1, 8'hC1);
    xckEdge(1'b1, txN, rxN, at);
    check(txN == 0 && rxN == 1, "R9 rise gives rx", txN * 10 + rxN, 1);
    check(at == 3, "R11 strobe latency pol1", at, 3);
    xckEdge(1'b0, txN, rxN, at);
    check(txN == 1 && rxN == 0, "R9 fall gives tx", txN * 10 + rxN, 10);

    // R10 async, polarity bit set but ignored
    busWrite(1'b1, 8'h81);
    xckEdge(1'b1, txN, rxN, at);
    check(txN == 1 && rxN == 0, "R10 async rise gives tx", txN * 10 + rxN, 10);
    xckEdge(1'b0, txN, rxN, at);
    check(txN == 0 && rxN == 1, "R10 async fall gives rx", txN * 10 + rxN, 1);

    // random divisors mixed with frame writes (R2 R4 R5 R6)
    for (int n = 0; n < 20; n++) begin
      int hi, lo, fr;
      hi = $urandom_range(1, 0);
      lo = $urandom_range(255, 0);
      fr = $urandom_range(127, 0);
      busWrite(1'b1, 8'(8'h80 | fr));
      check(frameCtrl == 7'(fr), "R4 random frame", frameCtrl, fr);
      loadAndMeasure(hi, lo, f, p);
      check(f == divOf(hi, lo), "R5 random first tick", f, divOf(hi, lo));
      check(p == divOf(hi, lo) + 1, "R6 random period", p, divOf(hi, lo) + 1);
      busRead(1'b1, v); check(v == hi, "R2 random high readback", v, hi);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule